// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, date, month, year, a century byte and a three-bit weekday counter. It advances by one second on each cycle in which a one-second enable pulse is high. The carry ripples through every field in that same cycle. The hour byte selects between 24-hour and 12-hour counting and holds a PM flag in 12-hour mode. February gets a 29th day in every year whose two-digit value is a multiple of four.

A host writes any field through a byte-wide register port. Field addresses are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday, 7 century. A host never reads the live counters directly. It first pulses a capture input, which copies all eight fields at once into a holding buffer. It then reads that buffer by address, so a multi-byte read sees one instant of time.

A power-loss input models a complete loss of both supplies. It reloads every field with its default, sets a fail flag and freezes counting. Counting resumes after the host writes any field.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the fail flag is 1 and the fields read back as seconds 00h, minutes 00h, hour 12h (12-hour mode, AM, twelve o'clock), date 01h, month 01h, year 00h, weekday 00h, century 20h.
- R2: Seconds and minutes count 00 to 59 in BCD. A tick at 59 seconds gives 00 and advances minutes, and minutes at 59 wrap to 00 and advance the hour.
- R3: When hour bit 7 is 1 (24-hour mode), hours count 00 to 23 in bits 5:0. A tick at 23:59:59 gives 00, keeps bit 7 and advances the date and weekday.
- R4: When hour bit 7 is 0 (12-hour mode), bits 4:0 count 1 to 12 and bit 5 is PM (1 = PM). Hour 11 goes to 12 and toggles PM. Hour 12 goes to 01 and leaves PM unchanged. The day advances only on the step from 11 PM to 12 AM.
- R5: Past the last day of the month, the date returns to 01 and the month advances. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February.
- R6: February ends on day 29 when the year value is divisible by 4, otherwise on day 28.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00, and at that step a century of 19h becomes 20h.
- R8: The weekday advances once per day through 0 to 6 and then wraps to 0.
- R9: While the fail flag is set, ticks do not change any field. Any field write clears the flag, and counting resumes after it.
- R10: A write is visible on the cycle after the write strobe. A tick in the same cycle as the write is dropped.
- R11: A capture pulse copies all fields as they stand before that edge's tick. The read data changes only on a capture, a power loss or a change of read address.
- R12: A power-loss pulse reloads the R1 defaults into the fields and the buffer and sets the fail flag, even when a write arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset, treated as first power-up |
| tick | input | 1 | One-second enable pulse, one cycle wide |
| pwrLoss | input | 1 | Complete power loss seen; reload defaults |
| wrEn | input | 1 | Field write strobe |
| wrAddr | input | 3 | Field address to write |
| wrData | input | 8 | BCD value to write |
| snapReq | input | 1 | Capture all fields into the read buffer |
| rdAddr | input | 3 | Field address to read from the buffer |
| rdData | output | 8 | Captured field value |
| failFlag | output | 1 | Clock invalid after power loss; frozen until a write |

## Verification
Two collisions matter. A tick can meet a capture pulse, and a tick can meet a write. For the first, the bench raises capture and tick in the same cycle. The captured seconds must show the value before the tick, and the next capture must show the advanced value. For the second, the bench writes the seconds with tick high. It expects exactly the written value, and then one more count after a later lone tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 8;
  localparam int ADDR_W     = $clog2(NUM_FIELDS);

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam int IDX_DOW  = 6;
  localparam int IDX_CENT = 7;

  typedef struct packed {
    logic loadDef;
    logic wrStb;
    logic advance;
    logic capture;
  } rtcStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] fieldDefault(input int idx);
    case (idx)
      IDX_HOUR: return 8'h12;
      IDX_DATE: return 8'h01;
      IDX_MON:  return 8'h01;
      IDX_CENT: return 8'h20;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       pwrLoss,
  input  logic       wrEn,
  input  logic       snapReq,
  output rtcStrobe_t strobe,
  output logic       failFlag
);
  always_comb begin
    strobe.loadDef = pwrLoss;
    strobe.wrStb   = wrEn && !pwrLoss;
    strobe.advance = tick && !wrEn && !pwrLoss && !failFlag;
    strobe.capture = snapReq && !pwrLoss;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        failFlag <= 1'b1;
    else if (pwrLoss) failFlag <= 1'b1;
    else if (wrEn)    failFlag <= 1'b0;
  end
endmodule

// File: rtl/rtc_cal_dp.sv
module rtc_cal_dp
  import rtc_cal_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = NUM_FIELDS,
  parameter int AW = ADDR_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobe_t       strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [FW-1:0]    wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [FW-1:0]    rdData,
  output logic [NF*FW-1:0] liveBus
);
  logic [FW-1:0] live     [NF];
  logic [FW-1:0] snap     [NF];
  logic [FW-1:0] nextLive [NF];

  logic [7:0] sec, min, hr, date, mon, yr, dow, cent;
  logic [7:0] hInc24, hInc12, hrNext, lastDay;
  logic       cMin, cHour, cDay, cMonth, cYear, leap;
  logic [4:0] mod4Sum;

  assign sec  = live[IDX_SEC];
  assign min  = live[IDX_MIN];
  assign hr   = live[IDX_HOUR];
  assign date = live[IDX_DATE];
  assign mon  = live[IDX_MON];
  assign yr   = live[IDX_YEAR];
  assign dow  = live[IDX_DOW];
  assign cent = live[IDX_CENT];

  // Carry chain and per-field successors
  always_comb begin
    hInc24 = bcdInc({2'b00, hr[5:0]});
    hInc12 = bcdInc({3'b000, hr[4:0]});
    cMin   = (sec == 8'h59);
    cHour  = cMin && (min == 8'h59);
    cDay   = 1'b0;
    if (hr[7]) begin
      if (hr[5:0] == 6'h23) begin
        hrNext = {hr[7], 7'h00};
        cDay   = cHour;
      end else begin
        hrNext = {hr[7:6], hInc24[5:0]};
      end
    end else if (hr[4:0] == 5'h11) begin
      hrNext = {hr[7:6], ~hr[5], 5'h12};
      cDay   = cHour && hr[5];
    end else if (hr[4:0] == 5'h12) begin
      hrNext = {hr[7:6], hr[5], 5'h01};
    end else begin
      hrNext = {hr[7:6], hr[5], hInc12[4:0]};
    end

    mod4Sum = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    leap    = (mod4Sum[1:0] == 2'b00);
    case (mon)
      8'h02:                      lastDay = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
    cMonth = cDay && (date == lastDay);
    cYear  = cMonth && (mon == 8'h12);

    for (int i = 0; i < NF; i++) nextLive[i] = live[i];
    nextLive[IDX_SEC] = cMin ? 8'h00 : bcdInc(sec);
    if (cMin)  nextLive[IDX_MIN]  = (min == 8'h59) ? 8'h00 : bcdInc(min);
    if (cHour) nextLive[IDX_HOUR] = hrNext;
    if (cDay) begin
      nextLive[IDX_DATE] = cMonth ? 8'h01 : bcdInc(date);
      nextLive[IDX_DOW]  = (dow[2:0] == 3'd6) ? 8'h00 : {5'b0, dow[2:0] + 3'd1};
    end
    if (cMonth) nextLive[IDX_MON] = (mon == 8'h12) ? 8'h01 : bcdInc(mon);
    if (cYear) begin
      nextLive[IDX_YEAR] = (yr == 8'h99) ? 8'h00 : bcdInc(yr);
      if (yr == 8'h99 && cent == 8'h19) nextLive[IDX_CENT] = 8'h20;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : gField
    always_ff @(posedge clk) begin
      if (!rstN || strobe.loadDef)
        live[g] <= fieldDefault(g);
      else if (strobe.wrStb && wrAddr == AW'(g))
        live[g] <= wrData;
      else if (strobe.advance)
        live[g] <= nextLive[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.loadDef) snap[g] <= fieldDefault(g);
      else if (strobe.capture)     snap[g] <= live[g];
    end

    assign liveBus[g*FW +: FW] = live[g];
  end

  assign rdData = snap[rdAddr];
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
  import rtc_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                pwrLoss,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [FIELD_W-1:0]  wrData,
  input  logic                snapReq,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [FIELD_W-1:0]  rdData,
  output logic                failFlag
);
  rtcStrobe_t                     strobe;
  logic [NUM_FIELDS*FIELD_W-1:0]  liveBus;

  rtc_cal_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .pwrLoss(pwrLoss),
    .wrEn(wrEn), .snapReq(snapReq), .strobe(strobe), .failFlag(failFlag)
  );

  rtc_cal_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .liveBus(liveBus)
  );
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk
  import rtc_cal_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            pwrLoss,
  input logic                            wrEn,
  input logic [ADDR_W-1:0]               wrAddr,
  input logic [FIELD_W-1:0]              wrData,
  input logic                            snapReq,
  input logic [ADDR_W-1:0]               rdAddr,
  input logic [FIELD_W-1:0]              rdData,
  input logic                            failFlag,
  input logic [NUM_FIELDS*FIELD_W-1:0]   liveBus
);
  logic [FIELD_W-1:0] fld [NUM_FIELDS];
  always_comb
    for (int i = 0; i < NUM_FIELDS; i++) fld[i] = liveBus[i*FIELD_W +: FIELD_W];

  a_r12_loss_sets_fail: assert property (@(posedge clk) disable iff (!rstN)
    pwrLoss |=> failFlag);

  a_r12_loss_reloads: assert property (@(posedge clk) disable iff (!rstN)
    pwrLoss |=> (fld[IDX_SEC] == 8'h00 && fld[IDX_CENT] == 8'h20));

  a_r9_write_clears_fail: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !pwrLoss) |=> !failFlag);

  a_r9_frozen_while_failed: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !wrEn && !pwrLoss) |=> $stable(liveBus));

  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !pwrLoss) |=> fld[$past(wrAddr)] == $past(wrData));

  a_r11_buffer_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!snapReq && !pwrLoss) |=> (rdData == $past(rdData) || rdAddr != $past(rdAddr)));

  a_r2_sec_is_bcd: assert property (@(posedge clk) disable iff (!rstN)
    (fld[IDX_SEC][3:0] <= 4'd9 && fld[IDX_SEC][7:4] <= 4'd5));
endmodule

bind rtc_cal_top rtc_cal_chk uChk (
  .clk(clk), .rstN(rstN), .pwrLoss(pwrLoss), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .snapReq(snapReq), .rdAddr(rdAddr), .rdData(rdData),
  .failFlag(failFlag), .liveBus(liveBus)
);

// File: tb/rtc_cal_top_test.sv
`timescale 1ns/1ps
module rtc_cal_top_test;
  // Field packing in vectors: {cent, dow, year, month, date, hour, min, sec}
  logic       clk = 1'b0;
  logic       rstN = 1'b0, tick = 1'b0, pwrLoss = 1'b0, wrEn = 1'b0, snapReq = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       failFlag;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rtc_cal_top uut (
    .clk(clk), .rstN(rstN), .tick(tick), .pwrLoss(pwrLoss), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .snapReq(snapReq), .rdAddr(rdAddr),
    .rdData(rdData), .failFlag(failFlag)
  );

  localparam int NV = 15;
  localparam logic [127:0] VEC [NV] = '{
    {64'h20_03_24_05_10_85_30_15, 64'h20_03_24_05_10_85_30_16}, // R2 plain second
    {64'h20_03_24_05_10_85_59_59, 64'h20_03_24_05_10_86_00_00}, // R2 sec+min wrap
    {64'h20_06_24_05_10_A3_59_59, 64'h20_00_24_05_11_80_00_00}, // R3 R8 midnight 24h
    {64'h20_01_24_05_10_11_59_59, 64'h20_01_24_05_10_32_00_00}, // R4 11AM to 12PM
    {64'h20_01_24_05_10_32_59_59, 64'h20_01_24_05_10_21_00_00}, // R4 12PM to 1PM
    {64'h20_01_24_05_10_31_59_59, 64'h20_02_24_05_11_12_00_00}, // R4 11PM to 12AM
    {64'h20_02_23_04_30_A3_59_59, 64'h20_03_23_05_01_80_00_00}, // R5 30-day month
    {64'h20_00_24_01_30_A3_59_59, 64'h20_01_24_01_31_80_00_00}, // R5 31-day month
    {64'h20_02_23_02_28_A3_59_59, 64'h20_03_23_03_01_80_00_00}, // R6 Feb common
    {64'h20_02_24_02_28_A3_59_59, 64'h20_03_24_02_29_80_00_00}, // R6 Feb leap 28
    {64'h20_02_24_02_29_A3_59_59, 64'h20_03_24_03_01_80_00_00}, // R6 Feb leap 29
    {64'h20_02_12_02_28_A3_59_59, 64'h20_03_12_02_29_80_00_00}, // R6 leap year 12
    {64'h20_02_10_02_28_A3_59_59, 64'h20_03_10_03_01_80_00_00}, // R6 year 10 common
    {64'h20_04_23_12_31_A3_59_59, 64'h20_05_24_01_01_80_00_00}, // R7 year end
    {64'h19_04_99_12_31_A3_59_59, 64'h20_05_00_01_01_80_00_00}  // R7 century step
  };
  localparam string VTAG [NV] = '{"R2","R2","R3","R4","R4","R4","R5","R5",
                                  "R6","R6","R6","R6","R6","R7","R7"};
  localparam logic [63:0] DEFAULTS = 64'h20_00_00_01_01_12_00_00;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeField(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic readAll(output logic [63:0] v);
    @(negedge clk); snapReq = 1'b1;
    @(negedge clk); snapReq = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rdAddr = 3'(i); #0.2;
      v[i*8 +: 8] = rdData;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] got;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 defaults and fail flag
    check("R1 fail", {63'b0, failFlag}, 64'd1);
    readAll(got);
    check("R1 defaults", got, DEFAULTS);

    // R9 frozen while failed
    repeat (3) tickOnce();
    readAll(got);
    check("R9 frozen", got, DEFAULTS);

    // R9 first write clears flag and counting resumes
    writeField(3'd0, 8'h05);
    check("R9 cleared", {63'b0, failFlag}, 64'd0);
    tickOnce();
    readAll(got);
    check("R9 resumes", got, {DEFAULTS[63:8], 8'h06});

    // R10 write wins over a tick in the same cycle
    @(negedge clk); wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h40; tick = 1'b1;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    readAll(got);
    check("R10 tick dropped", got, {DEFAULTS[63:8], 8'h40});
    tickOnce();
    readAll(got);
    check("R10 next tick", got, {DEFAULTS[63:8], 8'h41});

    // R11 capture coincides with a tick
    @(negedge clk); snapReq = 1'b1; tick = 1'b1;
    @(negedge clk); snapReq = 1'b0; tick = 1'b0;
    rdAddr = 3'd0; #0.2;
    check("R11 pre-tick value", {56'b0, rdData}, 64'h41);
    tickOnce();
    tickOnce();
    rdAddr = 3'd0; #0.2;
    check("R11 buffer held", {56'b0, rdData}, 64'h41);
    readAll(got);
    check("R11 live advanced", got, {DEFAULTS[63:8], 8'h44});

    // R12 power loss beats a write in the same cycle
    @(negedge clk); pwrLoss = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h33;
    @(negedge clk); pwrLoss = 1'b0; wrEn = 1'b0;
    rdAddr = 3'd0; #0.2;
    check("R12 buffer reloaded", {56'b0, rdData}, 64'h00);
    check("R12 fail set", {63'b0, failFlag}, 64'd1);
    readAll(got);
    check("R12 defaults", got, DEFAULTS);

    // Table walk: load start time, one tick, compare all fields
    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 8; f++) writeField(3'(f), VEC[v][64 + f*8 +: 8]);
      tickOnce();
      readAll(got);
      check(VTAG[v], got, VEC[v][63:0]);
    end

    // R8 weekday wraps across two midnights
    for (int f = 0; f < 8; f++) writeField(3'(f), 8'h00);
    writeField(3'd6, 8'h05);
    writeField(3'd2, 8'hA3); writeField(3'd1, 8'h59); writeField(3'd0, 8'h59);
    writeField(3'd3, 8'h10); writeField(3'd4, 8'h07); writeField(3'd7, 8'h20);
    tickOnce();
    readAll(got);
    check("R8 to six", got[55:48], 8'h06);
    writeField(3'd2, 8'hA3); writeField(3'd1, 8'h59); writeField(3'd0, 8'h59);
    tickOnce();
    readAll(got);
    check("R8 wrap", got, 64'h20_00_00_07_12_80_00_00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule